// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by fetching page table entries from memory, one level at a time, through a radix tree of four levels. A walk starts at the frame of the top-level table, given by the root frame input, and uses one nine-bit slice of the virtual page number per level to choose an eight-byte entry. Each present entry names the physical frame of the next table. The walk ends with a translation ready to install in the TLB, or with a page fault that reports the faulting virtual address.

A walk may stop early. An entry at the second level with its large-page bit set maps a 1 GiB region, and one at the third level maps a 2 MiB region. Permissions are gathered along the path: a page is writable or user-accessible only if every level grants it, and it is no-execute if any level forbids execution. The requested access type is checked against the gathered permissions. A failed check yields a permission fault rather than a fill.

Only one walk runs at a time. A miss request is taken while `busy` is low. Each walk issues its reads in order through a read port with one request outstanding. The request side uses valid and ready, and the response side uses a valid strobe.

Top module: `radix_walker`

## Requirements
- R1: After reset `busy`, `fill_valid`, `fault_valid` and `mem_req_valid` are low.
- R2: A miss is accepted at a clock edge where `busy` is low and `miss_valid` is high. `busy` is high from the next cycle until the report. Miss inputs have no effect while `busy` is high. In the report cycle `busy` is low, so a new miss can be accepted in that same cycle.
- R3: The first read address is {root_frame, va[47:39], 3'b000}. Each later read is {entry[51:12] of the previous level, next slice, 3'b000}. The slices are used in the order va[38:30], va[29:21], va[20:12].
- R4: `mem_req_valid` stays high, with `mem_req_addr` unchanged, until `mem_req_ready` is high. Only one read is outstanding at a time.
- R5: An entry with bit 0 (present) clear at any level ends the walk. No further read is issued. `fault_valid` pulses with `fault_va` equal to the full miss address and `fault_perm` = 0.
- R6: At the second level, bit 7 set makes a 1 GiB leaf after 2 reads. In the fill, `fill_size` = 2, `fill_pfn` = entry[51:12] with its low 18 bits zeroed, and `fill_vpn` = va[47:12] with its low 18 bits zeroed.
- R7: At the third level, bit 7 set makes a 2 MiB leaf after 3 reads. In the fill, `fill_size` = 1, and the low 9 bits of both `fill_pfn` and `fill_vpn` are zeroed.
- R8: Bit 7 has no effect at the top level, where the entry is still a table pointer, and none at the fourth level, where the entry is still a 4 KiB leaf.
- R9: A walk through all four levels makes exactly 4 reads. In the fill, `fill_size` = 0, `fill_pfn` = entry[51:12] and `fill_vpn` = va[47:12].
- R10: `fill_writable` is the AND of bit 1 over all fetched levels. `fill_user` is the AND of bit 2 over all fetched levels. `fill_noexec` is the OR of bit 63 over all fetched levels.
- R11: A leaf gives a fault with `fault_perm` = 1, and no fill, in any of three cases: a write access when the page is not writable, a user access when the page is not user-accessible, or an execute access when the page is no-execute.
- R12: Each accepted miss gives exactly one one-cycle pulse, either on `fill_valid` or on `fault_valid`, and never on both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_frame | input | 40 | Physical frame of the top-level table, sampled when a miss is accepted |
| miss_valid | input | 1 | Miss request present |
| miss_va | input | 48 | Missing virtual address |
| miss_write | input | 1 | Access is a write |
| miss_user | input | 1 | Access is from user mode |
| miss_exec | input | 1 | Access is an instruction fetch |
| busy | output | 1 | Walk in progress; new misses are not taken |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| fill_valid | output | 1 | One-cycle fill strobe |
| fill_vpn | output | 36 | Virtual page number of the mapping, aligned to its size |
| fill_pfn | output | 40 | Physical frame of the mapping, aligned to its size |
| fill_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_writable | output | 1 | Combined write permission |
| fill_user | output | 1 | Combined user permission |
| fill_noexec | output | 1 | Combined no-execute flag |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_va | output | 48 | Faulting virtual address |
| fault_perm | output | 1 | 1 = permission fault, 0 = not-present fault |

## Verification
Two events can fall in one cycle: the report of one walk and the acceptance of the next miss. The bench provokes this by keeping `miss_valid` high with a second address for the whole of a first walk. It judges three things. The first walk's result must be untouched by the changed inputs. `busy` must be high in the cycle after the report. The second walk must give the result its own table path predicts.

// File: rtl/rwalk_pkg.sv
// Shared constants and types of the page table walker.
// Assumes 48-bit virtual and 52-bit physical addresses with 4 KiB base pages.
package rwalk_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int OFS_W    = 12;
    localparam int IDX_W    = 9;
    localparam int LEVELS   = 4;
    localparam int PTE_W    = 64;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int FRAME_W  = PA_W - OFS_W;
    localparam int VPN_W    = VA_W - OFS_W;
    localparam int ENT_SH   = $clog2(PTE_W / 8);

    localparam int B_PRESENT = 0;
    localparam int B_WRITE   = 1;
    localparam int B_USER    = 2;
    localparam int B_LARGE   = 7;
    localparam int B_NOEXEC  = 63;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_REQ,
        WS_WAIT
    } walk_state_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } perm_t;
endpackage

// File: rtl/rwalk_index.sv
// Forms the physical byte address of the entry read at one level.
// Assumes one nine-bit index per level taken from the VPN, top level first,
// and that a table occupies exactly one base page.
module rwalk_index
    import rwalk_pkg::*;
(
    input  logic [VPN_W-1:0]   vpn,
    input  logic [LVL_W-1:0]   level,
    input  logic [FRAME_W-1:0] table_frame,
    output logic [PA_W-1:0]    entry_addr
);
    logic [IDX_W-1:0] slice [LEVELS];

    // one index slice per level, most significant slice for level 0
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    // table base plus index scaled by the entry size
    assign entry_addr = {table_frame, slice[level], {ENT_SH{1'b0}}};
endmodule

// File: rtl/rwalk_perm.sv
// Gathers permission bits along one walk.
// Assumes start clears the accumulator and take folds in one present entry.
module rwalk_perm
    import rwalk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  take,
    input  logic  wr_bit,
    input  logic  usr_bit,
    input  logic  nx_bit,
    output perm_t merged
);
    perm_t acc;

    // permissions of the levels already passed combined with the current entry
    always_comb begin
        merged.wr  = acc.wr  & wr_bit;
        merged.usr = acc.usr & usr_bit;
        merged.nx  = acc.nx  | nx_bit;
    end

    // accumulator: reopened per walk, narrowed per fetched level
    always_ff @(posedge clk) begin
        if (!rst_n || start) acc <= '{wr: 1'b1, usr: 1'b1, nx: 1'b0};
        else if (take)       acc <= merged;
    end

    // R10
    wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !acc.wr) |=> !acc.wr);
    // R10
    nx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && acc.nx) |=> acc.nx);
endmodule

// File: rtl/radix_walker.sv
// Four-level page table walker with early exit on 1 GiB and 2 MiB leaves.
// Assumes a single-outstanding memory read port and one walk at a time.
// Results appear as one-cycle pulses on the fill or fault outputs.
module radix_walker
    import rwalk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               miss_valid,
    input  logic [VA_W-1:0]    miss_va,
    input  logic               miss_write,
    input  logic               miss_user,
    input  logic               miss_exec,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [FRAME_W-1:0] fill_pfn,
    output logic [1:0]         fill_size,
    output logic               fill_writable,
    output logic               fill_user,
    output logic               fill_noexec,
    output logic               fault_valid,
    output logic [VA_W-1:0]    fault_va,
    output logic               fault_perm
);
    walk_state_e        state;
    logic [LVL_W-1:0]   lvl;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] frame_q;
    logic               acc_w_q, acc_u_q, acc_x_q;
    logic               start, take, present, leaf, denied;
    logic [1:0]         size;
    logic [FRAME_W-1:0] low_mask;
    perm_t              merged;
    logic               rsvd_unused;

    // bits of the entry this walker does not interpret
    assign rsvd_unused = ^{mem_rsp_data[PTE_W-2:PA_W], mem_rsp_data[B_LARGE-1:B_USER+1],
                           mem_rsp_data[OFS_W-1:B_LARGE+1]};

    // handshake and decode of the entry being returned
    assign start   = (state == WS_IDLE) && miss_valid;
    assign take    = (state == WS_WAIT) && mem_rsp_valid;
    assign present = mem_rsp_data[B_PRESENT];
    assign leaf    = (lvl == LVL_W'(LEVELS-1)) ||
                     (mem_rsp_data[B_LARGE] && (lvl == LVL_W'(1) || lvl == LVL_W'(2)));
    assign size     = 2'(LEVELS-1) - 2'(lvl);
    assign low_mask = (FRAME_W'(1) << (IDX_W * int'(size))) - FRAME_W'(1);
    assign denied   = (acc_w_q & ~merged.wr) | (acc_u_q & ~merged.usr) | (acc_x_q & merged.nx);

    assign busy          = (state != WS_IDLE);
    assign mem_req_valid = (state == WS_REQ);

    rwalk_index u_index (
        .vpn         (va_q[VA_W-1:OFS_W]),
        .level       (lvl),
        .table_frame (frame_q),
        .entry_addr  (mem_req_addr)
    );

    rwalk_perm u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .take    (take),
        .wr_bit  (mem_rsp_data[B_WRITE]),
        .usr_bit (mem_rsp_data[B_USER]),
        .nx_bit  (mem_rsp_data[B_NOEXEC]),
        .merged  (merged)
    );

    // walk sequencer and registered result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= WS_IDLE;
            lvl           <= '0;
            va_q          <= '0;
            frame_q       <= '0;
            acc_w_q       <= 1'b0;
            acc_u_q       <= 1'b0;
            acc_x_q       <= 1'b0;
            fill_valid    <= 1'b0;
            fill_vpn      <= '0;
            fill_pfn      <= '0;
            fill_size     <= '0;
            fill_writable <= 1'b0;
            fill_user     <= 1'b0;
            fill_noexec   <= 1'b0;
            fault_valid   <= 1'b0;
            fault_va      <= '0;
            fault_perm    <= 1'b0;
        end else begin
            fill_valid  <= 1'b0;
            fault_valid <= 1'b0;
            unique case (state)
                WS_IDLE: if (miss_valid) begin
                    va_q    <= miss_va;
                    acc_w_q <= miss_write;
                    acc_u_q <= miss_user;
                    acc_x_q <= miss_exec;
                    frame_q <= root_frame;
                    lvl     <= '0;
                    state   <= WS_REQ;
                end
                WS_REQ: if (mem_req_ready) state <= WS_WAIT;
                WS_WAIT: if (mem_rsp_valid) begin
                    if (!present) begin
                        fault_valid <= 1'b1;
                        fault_va    <= va_q;
                        fault_perm  <= 1'b0;
                        state       <= WS_IDLE;
                    end else if (leaf) begin
                        state <= WS_IDLE;
                        if (denied) begin
                            fault_valid <= 1'b1;
                            fault_va    <= va_q;
                            fault_perm  <= 1'b1;
                        end else begin
                            fill_valid    <= 1'b1;
                            fill_vpn      <= va_q[VA_W-1:OFS_W] & ~low_mask[VPN_W-1:0];
                            fill_pfn      <= mem_rsp_data[PA_W-1:OFS_W] & ~low_mask;
                            fill_size     <= size;
                            fill_writable <= merged.wr;
                            fill_user     <= merged.usr;
                            fill_noexec   <= merged.nx;
                        end
                    end else begin
                        frame_q <= mem_rsp_data[PA_W-1:OFS_W];
                        lvl     <= lvl + 1'b1;
                        state   <= WS_REQ;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R12
    one_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));
    // R2
    report_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |-> !busy);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> busy);
    // R12
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> !(fill_valid || fault_valid));
    // R6
    size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_size != 2'd3));
endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;
    import rwalk_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [FRAME_W-1:0] root_frame = '0;
    logic miss_valid = 1'b0, miss_write = 1'b0, miss_user = 1'b0, miss_exec = 1'b0;
    logic [VA_W-1:0] miss_va = '0;
    logic busy, mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic fill_valid, fill_writable, fill_user, fill_noexec, fault_valid, fault_perm;
    logic [VPN_W-1:0] fill_vpn;
    logic [FRAME_W-1:0] fill_pfn;
    logic [1:0] fill_size;
    logic [VA_W-1:0] fault_va;

    logic [63:0] pmem [logic [51:0]];
    int checks = 0, errors = 0, reads = 0;
    logic [51:0] rd_log [4];
    bit done = 0;

    radix_walker i_radix_walker (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit flt; bit perm; bit [1:0] size; bit [39:0] pfn; bit [35:0] vpn;
        bit wr; bit usr; bit nx; int nreads; bit [51:0] addrs [4];
    } exp_t;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] mk(input logic [39:0] frame, input logic [11:0] flags, input bit nx);
        return {nx, 11'd0, frame, flags};
    endfunction

    // expected walk derived from the requirements
    function automatic exp_t ref_walk(input logic [47:0] va, input logic [39:0] root,
                                      input bit w, input bit u, input bit x);
        exp_t e;
        logic [39:0] frame = root, msk;
        logic [63:0] p;
        e.flt = 0; e.perm = 0; e.size = 0; e.pfn = 0; e.vpn = 0;
        e.wr = 1; e.usr = 1; e.nx = 0; e.nreads = 0;
        for (int l = 0; l < 4; l++) e.addrs[l] = '0;
        for (int l = 0; l < 4; l++) begin
            e.addrs[l] = {frame, va[47-9*l -: 9], 3'b000};
            e.nreads = l + 1;
            p = rd(e.addrs[l]);
            if (!p[0]) begin e.flt = 1; return e; end
            e.wr &= p[1]; e.usr &= p[2]; e.nx |= p[63];
            if (l == 3 || ((l == 1 || l == 2) && p[7])) begin
                e.size = 2'(3 - l);
                msk = (40'd1 << (9 * (3 - l))) - 40'd1;
                e.pfn = p[51:12] & ~msk;
                e.vpn = va[47:12] & ~msk[35:0];
                if ((w && !e.wr) || (u && !e.usr) || (x && e.nx)) begin e.flt = 1; e.perm = 1; end
                return e;
            end
            frame = p[51:12];
        end
        return e;
    endfunction

    // memory model: random ready, random latency, read log
    int dly = 0;
    bit pend = 0, pv = 0, pr = 0;
    logic [51:0] paddr, pa_prev;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (!rst_n) begin
            pend = 0; mem_req_ready = 1'b0; pv = 0;
        end else begin
            if (pv && !pr)
                chk(mem_req_valid && mem_req_addr == pa_prev, "R4", "request held",
                    {63'd0, mem_req_valid}, 64'd1);
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = rd(paddr); pend = 0;
                end else dly--;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                chk(!pend, "R4", "one outstanding", {63'd0, pend}, 64'd0);
                pend = 1; paddr = mem_req_addr; dly = $urandom % 3;
                if (reads < 4) rd_log[reads] = mem_req_addr;
                reads++;
            end
            pv = mem_req_valid; pr = mem_req_ready; pa_prev = mem_req_addr;
        end
    end

    task automatic wait_report();
        int guard = 0;
        while (!(fill_valid || fault_valid) && guard < 200) begin @(negedge clk); guard++; end
    endtask

    task automatic judge(input exp_t e, input logic [47:0] va, input string req);
        chk({fill_valid, fault_valid} == {!e.flt, e.flt}, "R12", {req, " outcome"},
            {62'd0, fill_valid, fault_valid}, {62'd0, !e.flt, e.flt});
        if (e.flt) begin
            chk(fault_va == va, "R5", {req, " fault_va"}, fault_va, va);
            chk(fault_perm == e.perm, "R11", {req, " fault_perm"}, fault_perm, e.perm);
        end else begin
            chk(fill_size == e.size, req, "size", fill_size, e.size);
            chk(fill_pfn == e.pfn, req, "pfn", fill_pfn, e.pfn);
            chk(fill_vpn == e.vpn, req, "vpn", fill_vpn, e.vpn);
            chk({fill_writable, fill_user, fill_noexec} == {e.wr, e.usr, e.nx}, "R10", {req, " perms"},
                {fill_writable, fill_user, fill_noexec}, {e.wr, e.usr, e.nx});
        end
    endtask

    task automatic run_one(input logic [47:0] va, input logic [39:0] root,
                           input bit w, input bit u, input bit x, input string req);
        exp_t e = ref_walk(va, root, w, u, x);
        @(negedge clk);
        while (busy) @(negedge clk);
        root_frame = root; miss_va = va; miss_write = w; miss_user = u; miss_exec = x;
        miss_valid = 1'b1; reads = 0;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy, "R2", {req, " busy after accept"}, {63'd0, busy}, 64'd1);
        wait_report();
        judge(e, va, req);
        chk(reads == e.nreads, "R3", {req, " read count"}, reads, e.nreads);
        for (int l = 0; l < e.nreads && l < 4; l++)
            chk(rd_log[l] == e.addrs[l], "R3", {req, " read addr"}, rd_log[l], e.addrs[l]);
        @(negedge clk);
        chk(!fill_valid && !fault_valid, "R12", {req, " single pulse"},
            {62'd0, fill_valid, fault_valid}, 64'd0);
    endtask

    task automatic plant(input logic [47:0] va, input logic [39:0] root,
                         input logic [63:0] e0, input logic [63:0] e1,
                         input logic [63:0] e2, input logic [63:0] e3);
        logic [63:0] ents [4];
        logic [39:0] frame = root;
        ents[0] = e0; ents[1] = e1; ents[2] = e2; ents[3] = e3;
        for (int l = 0; l < 4; l++) begin
            pmem[{frame, va[47-9*l -: 9], 3'b000}] = ents[l];
            frame = ents[l][51:12];
        end
    endtask

    task automatic build_random(input logic [47:0] va, input logic [39:0] root);
        logic [39:0] frame = root;
        logic [63:0] p;
        for (int l = 0; l < 4; l++) begin
            p = {$urandom, $urandom};
            p[0] = ($urandom % 14) != 0;
            p[1] = ($urandom % 5) != 0;
            p[2] = ($urandom % 5) != 0;
            p[63] = ($urandom % 6) == 0;
            if (l == 1 || l == 2) p[7] = ($urandom % 4) == 0;
            pmem[{frame, va[47-9*l -: 9], 3'b000}] = p;
            frame = p[51:12];
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [39:0] ROOT = 40'h00100;
    localparam logic [47:0] VA1  = 48'h1234_5678_9abc;
    localparam logic [47:0] VA2  = 48'h7f80_1c04_3123;

    initial begin
        logic [63:0] t0, t1, t2, t3;
        exp_t ea, eb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !fill_valid && !fault_valid && !mem_req_valid, "R1", "reset state",
            {60'd0, busy, fill_valid, fault_valid, mem_req_valid}, 64'd0);

        t0 = mk(40'h00200, 12'h007, 0); t1 = mk(40'h00300, 12'h007, 0);
        t2 = mk(40'h00400, 12'h007, 0); t3 = mk(40'habcde, 12'h007, 0);
        // R9 full 4 KiB walk
        plant(VA1, ROOT, t0, t1, t2, t3);
        run_one(VA1, ROOT, 1, 1, 1, "R9");
        // R7 2 MiB leaf at directory
        plant(VA1, ROOT, t0, t1, mk(40'h12345, 12'h087, 0), t3);
        run_one(VA1, ROOT, 0, 0, 0, "R7");
        // R6 1 GiB leaf at directory-pointer level
        plant(VA1, ROOT, t0, mk(40'hfedcb, 12'h087, 0), t2, t3);
        run_one(VA1, ROOT, 0, 1, 0, "R6");
        // R8 large bit at top and leaf levels ignored
        plant(VA1, ROOT, mk(40'h00200, 12'h087, 0), t1, t2, mk(40'h55555, 12'h087, 0));
        run_one(VA1, ROOT, 0, 0, 0, "R8");
        // R5 not present at each level
        for (int k = 0; k < 4; k++) begin
            plant(VA1, ROOT, (k == 0) ? 64'h0 : t0, (k == 1) ? mk(40'h00300, 12'h006, 0) : t1,
                  (k == 2) ? 64'h6 : t2, (k == 3) ? mk(40'habcde, 12'h0, 0) : t3);
            run_one(VA1, ROOT, 0, 0, 0, "R5");
        end
        // R10 / R11 permissions narrowed at middle levels
        plant(VA1, ROOT, t0, mk(40'h00300, 12'h005, 0), mk(40'h00400, 12'h007, 1), t3);
        run_one(VA1, ROOT, 0, 1, 0, "R10");
        run_one(VA1, ROOT, 1, 0, 0, "R11");
        run_one(VA1, ROOT, 0, 0, 1, "R11");
        plant(VA1, ROOT, t0, t1, mk(40'h00400, 12'h003, 0), t3);
        run_one(VA1, ROOT, 0, 1, 0, "R11");
        run_one(VA1, ROOT, 1, 0, 0, "R10");

        // R2 back-to-back: report and next accept in the same cycle
        plant(VA1, ROOT, t0, t1, t2, t3);
        plant(VA2, 40'h00900, mk(40'h00a00, 12'h007, 0), mk(40'h00b00, 12'h007, 0),
              mk(40'h77777, 12'h083, 0), t3);
        ea = ref_walk(VA1, ROOT, 0, 0, 0);
        eb = ref_walk(VA2, 40'h00900, 0, 0, 0);
        @(negedge clk);
        while (busy) @(negedge clk);
        root_frame = ROOT; miss_va = VA1; miss_write = 0; miss_user = 0; miss_exec = 0;
        miss_valid = 1'b1;
        @(negedge clk);
        miss_va = VA2; root_frame = 40'h00900;
        wait_report();
        judge(ea, VA1, "R2 first walk");
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy, "R2", "accept in report cycle", {63'd0, busy}, 64'd1);
        wait_report();
        judge(eb, VA2, "R2 second walk");

        // random trials
        for (int n = 0; n < 160; n++) begin
            logic [47:0] va = {$urandom, $urandom};
            logic [39:0] rt = {8'd0, $urandom} & 40'h0_fffff;
            bit w = $urandom, u = $urandom, x = $urandom;
            exp_t er;
            build_random(va, rt);
            er = ref_walk(va, rt, w, u, x);
            run_one(va, rt, w, u, x,
                    er.flt ? (er.perm ? "R11" : "R5") :
                    (er.size == 2 ? "R6" : (er.size == 1 ? "R7" : "R9")));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule